// File: doc/BRIEF.md
# Two-Way Cache Tag Controller with Line Locking

This block keeps the tag, valid, lock and replacement state for a two-way set-associative cache of 8 KB. The cache has 256 sets and 16-byte lines. A lookup presents a physical address. The block reports whether the line is present, which way holds it, and which way a refill would replace. A fill port installs a new tag. A command port locks, unlocks, invalidates or probes single lines. The data array, the refill sequencer and snooping belong to other blocks.

Each request is captured in a stage register. Its result is registered one clock later. All requests that share a stage cycle see the state as it was before any of them. Each set has one replacement bit that names its least recently used way. A locked line is never offered as a victim, even when the replacement bit points at it. When both ways of a set are locked, misses in that set cannot allocate and fills to it are dropped.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset every line is invalid and unlocked, and every set's replacement bit selects way 0. All response outputs are low, and the first miss in any set names victim way 0.
- R2: The address splits into a tag in bits [31:12], a set index in bits [11:4] and a byte offset in bits [3:0]. A lookup sampled on clock edge k drives `lk_resp_valid` high for one cycle after edge k+1. `lk_hit` is high only if a valid way of that set holds the tag, and `lk_way` then names that way.
- R3: A lookup hit or an accepted fill in way w makes the other way the least recently used way of that set. A lookup miss leaves the replacement state unchanged.
- R4: The victim is chosen in this order: an invalid unlocked way, with way 0 taking precedence over way 1; otherwise the least recently used way if both ways are unlocked; otherwise the single unlocked way. `lk_victim` reports this way on a miss and is 0 on a hit.
- R5: When both ways of the set are locked, a lookup miss raises `lk_no_alloc`. A fill of a missing line to that set raises `fill_blocked` and changes no state.
- R6: A fill of an absent line writes the tag into the victim way, marks the line valid and unlocked, and reports that way on `fill_way`. A fill of a line that is already present writes no tag and only updates the replacement state. Fill results appear with the same latency as lookups.
- R7: The lock command (`cmd_op` = 0) sets the lock bit of a line that hits and returns status 0 (done). A command of any kind that misses changes nothing and returns status 1 (miss). Command status appears with the same latency as lookups.
- R8: The unlock command (`cmd_op` = 1) clears the lock bit of a line that hits. The line stays valid.
- R9: The invalidate command (`cmd_op` = 2) clears both the valid bit and the lock bit of a line that hits. The probe command (`cmd_op` = 3) only reports hit (status 0) or miss (status 1).
- R10: A command that shares a stage cycle with a fill has no effect and returns status 2 (busy), while the fill proceeds. A lookup that shares a stage cycle with a fill or a command reports the state from before them.
- R11: Offset bits [3:0] have no effect on the hit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup physical address |
| lk_resp_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 1 | Hitting way |
| lk_victim | output | 1 | Way a refill would replace (miss only) |
| lk_no_alloc | output | 1 | Miss in a set whose two ways are locked |
| fill_req | input | 1 | Fill request |
| fill_addr | input | 32 | Address of the line being installed |
| fill_resp_valid | output | 1 | Fill result valid |
| fill_way | output | 1 | Way written or refreshed by the fill |
| fill_blocked | output | 1 | Fill dropped, both ways locked |
| cmd_req | input | 1 | Line command request |
| cmd_op | input | 2 | 0 lock, 1 unlock, 2 invalidate, 3 probe |
| cmd_addr | input | 32 | Address of the line the command targets |
| cmd_resp_valid | output | 1 | Command status valid |
| cmd_status | output | 2 | 0 done, 1 miss, 2 busy |

## Verification
The bench sets up sets where the least recently used way is locked. A design that let replacement order win over the lock would name the locked way as victim and overwrite it. It fills sets until both ways are locked. A design without the no-allocate path would either evict a locked line or report a bogus victim. It invalidates a locked line and then refills it. A design that cleared only the valid bit would leave a stale lock that blocks later allocation. It also issues a lookup together with a fill, and a fill together with a command. Reading state after the update, or letting the command slip through, would show up as a wrong hit result or a lock that appears from nowhere.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [1:0] {
        OP_LOCK   = 2'd0,
        OP_UNLOCK = 2'd1,
        OP_INVAL  = 2'd2,
        OP_PROBE  = 2'd3
    } line_cmd_e;

    typedef enum logic [1:0] {
        ST_DONE = 2'd0,
        ST_MISS = 2'd1,
        ST_BUSY = 2'd2
    } cmd_status_e;

    typedef struct packed {
        logic ok;
        logic way;
    } victim_t;

    typedef struct packed {
        logic hit;
        logic way;
    } match_t;

    // Replacement choice for one set: invalid-and-free first, then LRU, then the free one.
    function automatic victim_t pick_victim(input logic [1:0] vld,
                                            input logic [1:0] lck,
                                            input logic       lru);
        victim_t r;
        r.ok  = 1'b1;
        r.way = 1'b0;
        if (!vld[0] && !lck[0])      r.way = 1'b0;
        else if (!vld[1] && !lck[1]) r.way = 1'b1;
        else if (!lck[0] && !lck[1]) r.way = lru;
        else if (!lck[0])            r.way = 1'b0;
        else if (!lck[1])            r.way = 1'b1;
        else                         r.ok  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ctc_way_compare.sv
module ctc_way_compare
    import cache_tag_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic [1:0][TAG_W-1:0] way_tag,
    input  logic [1:0]            way_vld,
    input  logic [TAG_W-1:0]      probe_tag,
    output match_t                result
);
    logic [1:0] eq;

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign eq[w] = way_vld[w] && (way_tag[w] == probe_tag);
    end

    always_comb begin
        result.hit = |eq;
        result.way = eq[1] && !eq[0];
    end
endmodule

// File: rtl/ctc_victim_sel.sv
module ctc_victim_sel
    import cache_tag_pkg::*;
(
    input  logic [1:0] way_vld,
    input  logic [1:0] way_lck,
    input  logic       set_lru,
    output victim_t    choice
);
    always_comb choice = pick_victim(way_vld, way_lck, set_lru);
endmodule

// File: rtl/ctc_state_array.sv
module ctc_state_array #(
    parameter int INDEX_W = 8,
    parameter int TAG_W   = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    // read port A (lookup)
    input  logic [INDEX_W-1:0]       ra_idx,
    output logic [1:0][TAG_W-1:0]    ra_tag,
    output logic [1:0]               ra_vld,
    output logic [1:0]               ra_lck,
    output logic                     ra_lru,
    // read port B (fill or command)
    input  logic [INDEX_W-1:0]       rb_idx,
    output logic [1:0][TAG_W-1:0]    rb_tag,
    output logic [1:0]               rb_vld,
    output logic [1:0]               rb_lck,
    output logic                     rb_lru,
    // line update port
    input  logic [INDEX_W-1:0]       up_idx,
    input  logic                     up_way,
    input  logic                     up_install,
    input  logic [TAG_W-1:0]         up_tag,
    input  logic                     up_lock_set,
    input  logic                     up_lock_clr,
    input  logic                     up_inval,
    // replacement updates; port B wins on the same set
    input  logic                     lru_a_en,
    input  logic [INDEX_W-1:0]       lru_a_idx,
    input  logic                     lru_a_val,
    input  logic                     lru_b_en,
    input  logic [INDEX_W-1:0]       lru_b_idx,
    input  logic                     lru_b_val
);
    localparam int SETS = 1 << INDEX_W;

    logic [TAG_W-1:0] tag_q [SETS][2];
    logic [1:0]       vld_q [SETS];
    logic [1:0]       lck_q [SETS];
    logic [SETS-1:0]  lru_q;

    always_comb begin
        for (int w = 0; w < 2; w++) begin
            ra_tag[w] = tag_q[ra_idx][w];
            rb_tag[w] = tag_q[rb_idx][w];
        end
        ra_vld = vld_q[ra_idx];
        ra_lck = lck_q[ra_idx];
        ra_lru = lru_q[ra_idx];
        rb_vld = vld_q[rb_idx];
        rb_lck = lck_q[rb_idx];
        rb_lru = lru_q[rb_idx];
    end

    always_ff @(posedge clk) begin
        if (up_install) tag_q[up_idx][up_way] <= up_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                lck_q[s] <= '0;
            end
        end else begin
            if (up_install) begin
                vld_q[up_idx][up_way] <= 1'b1;
                lck_q[up_idx][up_way] <= 1'b0;
            end
            if (up_lock_set) lck_q[up_idx][up_way] <= 1'b1;
            if (up_lock_clr || up_inval) lck_q[up_idx][up_way] <= 1'b0;
            if (up_inval) vld_q[up_idx][up_way] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else begin
            if (lru_a_en) lru_q[lru_a_idx] <= lru_a_val;
            if (lru_b_en) lru_q[lru_b_idx] <= lru_b_val;
        end
    end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 4,
    parameter int INDEX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_resp_valid,
    output logic              lk_hit,
    output logic              lk_way,
    output logic              lk_victim,
    output logic              lk_no_alloc,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_resp_valid,
    output logic              fill_way,
    output logic              fill_blocked,
    input  logic              cmd_req,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_resp_valid,
    output logic [1:0]        cmd_status
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } req_t;

    typedef struct packed {
        logic              vld;
        line_cmd_e         op;
        logic [ADDR_W-1:0] addr;
    } cmd_req_t;

    // ---------------- request stage ----------------
    req_t     lk_q, fill_q;
    cmd_req_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_q   <= '0;
            fill_q <= '0;
            cmd_q  <= '0;
        end else begin
            lk_q   <= '{vld: lk_req,   addr: lk_addr};
            fill_q <= '{vld: fill_req, addr: fill_addr};
            cmd_q  <= '{vld: cmd_req,  op: line_cmd_e'(cmd_op), addr: cmd_addr};
        end
    end

    // ---------------- address split ----------------
    logic [ADDR_W-1:0]  op_addr;
    logic [INDEX_W-1:0] lk_idx, op_idx;
    logic [TAG_W-1:0]   lk_tag, op_tag;

    always_comb begin
        op_addr = fill_q.vld ? fill_q.addr : cmd_q.addr;
        lk_idx  = lk_q.addr[OFFSET_W +: INDEX_W];
        lk_tag  = lk_q.addr[ADDR_W-1 -: TAG_W];
        op_idx  = op_addr[OFFSET_W +: INDEX_W];
        op_tag  = op_addr[ADDR_W-1 -: TAG_W];
    end

    // ---------------- state read ----------------
    logic [1:0][TAG_W-1:0] ra_tag, rb_tag;
    logic [1:0]            ra_vld, ra_lck, rb_vld, rb_lck;
    logic                  ra_lru, rb_lru;

    // update controls
    logic              up_install, up_lock_set, up_lock_clr, up_inval, up_way;
    logic              lru_a_en, lru_a_val, lru_b_en, lru_b_val;

    ctc_state_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .ra_idx     (lk_idx),
        .ra_tag     (ra_tag),
        .ra_vld     (ra_vld),
        .ra_lck     (ra_lck),
        .ra_lru     (ra_lru),
        .rb_idx     (op_idx),
        .rb_tag     (rb_tag),
        .rb_vld     (rb_vld),
        .rb_lck     (rb_lck),
        .rb_lru     (rb_lru),
        .up_idx     (op_idx),
        .up_way     (up_way),
        .up_install (up_install),
        .up_tag     (op_tag),
        .up_lock_set(up_lock_set),
        .up_lock_clr(up_lock_clr),
        .up_inval   (up_inval),
        .lru_a_en   (lru_a_en),
        .lru_a_idx  (lk_idx),
        .lru_a_val  (lru_a_val),
        .lru_b_en   (lru_b_en),
        .lru_b_idx  (op_idx),
        .lru_b_val  (lru_b_val)
    );

    // ---------------- compare and victim ----------------
    match_t  lk_match, op_match;
    victim_t lk_vict, op_vict;

    ctc_way_compare #(.TAG_W(TAG_W)) u_cmp_lk (
        .way_tag  (ra_tag),
        .way_vld  (ra_vld),
        .probe_tag(lk_tag),
        .result   (lk_match)
    );

    ctc_way_compare #(.TAG_W(TAG_W)) u_cmp_op (
        .way_tag  (rb_tag),
        .way_vld  (rb_vld),
        .probe_tag(op_tag),
        .result   (op_match)
    );

    ctc_victim_sel u_vic_lk (
        .way_vld(ra_vld),
        .way_lck(ra_lck),
        .set_lru(ra_lru),
        .choice (lk_vict)
    );

    ctc_victim_sel u_vic_op (
        .way_vld(rb_vld),
        .way_lck(rb_lck),
        .set_lru(rb_lru),
        .choice (op_vict)
    );

    // ---------------- operation decode ----------------
    logic        fill_blk_c, fill_way_c;
    cmd_status_e cmd_stat_c;

    always_comb begin
        up_install  = 1'b0;
        up_lock_set = 1'b0;
        up_lock_clr = 1'b0;
        up_inval    = 1'b0;
        up_way      = op_match.way;
        lru_b_en    = 1'b0;
        lru_b_val   = 1'b0;
        fill_blk_c  = 1'b0;
        fill_way_c  = 1'b0;
        cmd_stat_c  = ST_DONE;

        lru_a_en  = lk_q.vld && lk_match.hit;
        lru_a_val = !lk_match.way;

        if (fill_q.vld) begin
            if (op_match.hit) begin
                fill_way_c = op_match.way;
                lru_b_en   = 1'b1;
                lru_b_val  = !op_match.way;
            end else if (op_vict.ok) begin
                up_install = 1'b1;
                up_way     = op_vict.way;
                fill_way_c = op_vict.way;
                lru_b_en   = 1'b1;
                lru_b_val  = !op_vict.way;
            end else begin
                fill_blk_c = 1'b1;
            end
            cmd_stat_c = ST_BUSY;
        end else if (cmd_q.vld) begin
            if (!op_match.hit) begin
                cmd_stat_c = ST_MISS;
            end else begin
                unique case (cmd_q.op)
                    OP_LOCK:   up_lock_set = 1'b1;
                    OP_UNLOCK: up_lock_clr = 1'b1;
                    OP_INVAL:  up_inval    = 1'b1;
                    OP_PROBE:  ;
                endcase
            end
        end
    end

    // ---------------- response registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            lk_resp_valid   <= 1'b0;
            lk_hit          <= 1'b0;
            lk_way          <= 1'b0;
            lk_victim       <= 1'b0;
            lk_no_alloc     <= 1'b0;
            fill_resp_valid <= 1'b0;
            fill_way        <= 1'b0;
            fill_blocked    <= 1'b0;
            cmd_resp_valid  <= 1'b0;
            cmd_status      <= 2'd0;
        end else begin
            lk_resp_valid   <= lk_q.vld;
            lk_hit          <= lk_q.vld && lk_match.hit;
            lk_way          <= lk_q.vld && lk_match.hit && lk_match.way;
            lk_victim       <= lk_q.vld && !lk_match.hit && lk_vict.ok && lk_vict.way;
            lk_no_alloc     <= lk_q.vld && !lk_match.hit && !lk_vict.ok;
            fill_resp_valid <= fill_q.vld;
            fill_way        <= fill_q.vld && fill_way_c;
            fill_blocked    <= fill_q.vld && fill_blk_c;
            cmd_resp_valid  <= cmd_q.vld;
            cmd_status      <= cmd_q.vld ? cmd_stat_c : ST_DONE;
        end
    end
endmodule

// File: rtl/cache_tag_ctrl_checker.sv
module cache_tag_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       lk_req,
    input logic       fill_req,
    input logic       cmd_req,
    input logic       lk_resp_valid,
    input logic       lk_hit,
    input logic       lk_no_alloc,
    input logic       fill_resp_valid,
    input logic       cmd_resp_valid,
    input logic [1:0] cmd_status
);
    p_lk_latency_r2: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> ##1 lk_resp_valid);

    p_lk_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> ##1 !lk_resp_valid);

    p_idle_outputs_r1: assert property (@(posedge clk) disable iff (rst)
        !lk_resp_valid |-> (!lk_hit && !lk_no_alloc));

    p_noalloc_only_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_resp_valid && lk_no_alloc) |-> !lk_hit);

    p_fill_latency_r6: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> ##1 fill_resp_valid);

    p_cmd_latency_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_req |=> ##1 cmd_resp_valid);

    p_busy_needs_fill_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_resp_valid && cmd_status == 2'd2) |-> fill_resp_valid);
endmodule

bind cache_tag_ctrl cache_tag_ctrl_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .lk_req         (lk_req),
    .fill_req       (fill_req),
    .cmd_req        (cmd_req),
    .lk_resp_valid  (lk_resp_valid),
    .lk_hit         (lk_hit),
    .lk_no_alloc    (lk_no_alloc),
    .fill_resp_valid(fill_resp_valid),
    .cmd_resp_valid (cmd_resp_valid),
    .cmd_status     (cmd_status)
);

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_resp_valid, lk_hit, lk_way, lk_victim, lk_no_alloc;
    logic        fill_req = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        fill_resp_valid, fill_way, fill_blocked;
    logic        cmd_req = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic        cmd_resp_valid;
    logic [1:0]  cmd_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cache_tag_ctrl u_dut (
        .clk(clk), .rst(rst),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_resp_valid(lk_resp_valid), .lk_hit(lk_hit), .lk_way(lk_way),
        .lk_victim(lk_victim), .lk_no_alloc(lk_no_alloc),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_resp_valid(fill_resp_valid), .fill_way(fill_way), .fill_blocked(fill_blocked),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_resp_valid(cmd_resp_valid), .cmd_status(cmd_status)
    );

    // behavioural reference state
    bit [19:0] m_tag [256][2];
    bit        m_vld [256][2];
    bit        m_lck [256][2];
    bit        m_lru [256];

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return {tag[19:0], set[7:0], off[3:0]};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void m_find(input logic [31:0] a, output bit hit, output bit way);
        int s = int'(a[11:4]);
        hit = 0; way = 0;
        for (int w = 1; w >= 0; w--)
            if (m_vld[s][w] && m_tag[s][w] == a[31:12]) begin hit = 1; way = w[0]; end
    endfunction

    function automatic void m_pick(input int s, output bit ok, output bit way);
        ok = 1; way = 0;
        if (!m_vld[s][0] && !m_lck[s][0]) way = 0;
        else if (!m_vld[s][1] && !m_lck[s][1]) way = 1;
        else if (!m_lck[s][0] && !m_lck[s][1]) way = m_lru[s];
        else if (!m_lck[s][0]) way = 0;
        else if (!m_lck[s][1]) way = 1;
        else ok = 0;
    endfunction

    // One stage cycle of requests; outputs checked on the second falling edge.
    task automatic run_op(input string req, input bit le, input logic [31:0] la,
                          input bit fe, input logic [31:0] fa,
                          input bit ce, input logic [1:0] cop, input logic [31:0] ca);
        bit lh, lw, lok, lv, fh, fw, fok, fv, ch, cw;
        int e_fw, e_blk, e_st;
        int ls = int'(la[11:4]);
        int fs = int'(fa[11:4]);
        int cs = int'(ca[11:4]);
        m_find(la, lh, lw);
        m_pick(ls, lok, lv);
        m_find(fa, fh, fw);
        m_pick(fs, fok, fv);
        m_find(ca, ch, cw);
        e_fw  = fh ? int'(fw) : (fok ? int'(fv) : 0);
        e_blk = (!fh && !fok) ? 1 : 0;
        e_st  = fe ? 2 : (ch ? 0 : 1);

        @(negedge clk);
        lk_req = le;   lk_addr = la;
        fill_req = fe; fill_addr = fa;
        cmd_req = ce;  cmd_op = cop; cmd_addr = ca;
        @(negedge clk);
        lk_req = 0; fill_req = 0; cmd_req = 0;
        chk(req, "lookup valid early", int'(lk_resp_valid), 0);
        @(negedge clk);
        chk(req, "lookup valid", int'(lk_resp_valid), int'(le));
        if (le) begin
            chk(req, "hit", int'(lk_hit), int'(lh));
            chk(req, "hit way", int'(lk_way), lh ? int'(lw) : 0);
            chk(req, "victim", int'(lk_victim), (!lh && lok) ? int'(lv) : 0);
            chk(req, "no_alloc", int'(lk_no_alloc), (!lh && !lok) ? 1 : 0);
        end
        chk(req, "fill valid", int'(fill_resp_valid), int'(fe));
        if (fe) begin
            chk(req, "fill way", int'(fill_way), e_fw);
            chk(req, "fill blocked", int'(fill_blocked), e_blk);
        end
        chk(req, "cmd valid", int'(cmd_resp_valid), int'(ce));
        if (ce) chk(req, "cmd status", int'(cmd_status), e_st);

        // apply updates: lookup first, fill last so it wins the LRU bit
        if (le && lh) m_lru[ls] = !lw;
        if (ce && !fe && ch) begin
            case (cop)
                2'd0: m_lck[cs][cw] = 1;
                2'd1: m_lck[cs][cw] = 0;
                2'd2: begin m_lck[cs][cw] = 0; m_vld[cs][cw] = 0; end
                default: ;
            endcase
        end
        if (fe) begin
            if (fh) m_lru[fs] = !fw;
            else if (fok) begin
                m_tag[fs][fv] = fa[31:12];
                m_vld[fs][fv] = 1;
                m_lck[fs][fv] = 0;
                m_lru[fs] = !fv;
            end
        end
    endtask

    task automatic look(input string req, input logic [31:0] a);
        run_op(req, 1, a, 0, '0, 0, 2'd0, '0);
    endtask
    task automatic fill(input string req, input logic [31:0] a);
        run_op(req, 0, '0, 1, a, 0, 2'd0, '0);
    endtask
    task automatic cmd(input string req, input logic [1:0] op, input logic [31:0] a);
        run_op(req, 0, '0, 0, '0, 1, op, a);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] A, B, C, D;
        A = mk(1, 5, 0); B = mk(2, 5, 0); C = mk(3, 5, 0); D = mk(4, 5, 0);
        for (int s = 0; s < 256; s++) begin
            m_vld[s] = '{0, 0}; m_lck[s] = '{0, 0}; m_lru[s] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "reset lookup valid", int'(lk_resp_valid), 0);
        chk("R1", "reset fill valid", int'(fill_resp_valid), 0);
        chk("R1", "reset cmd valid", int'(cmd_resp_valid), 0);
        rst = 0;

        look("R1", A);                       // miss, victim 0
        fill("R6", A);                       // way 0
        look("R2", A);                       // hit way 0
        look("R11", mk(1, 5, 15));           // offset ignored
        look("R11", mk(1, 5, 7));
        fill("R4", B);                       // invalid way 1 first
        look("R2", B);                       // hit way 1, LRU -> 0
        look("R3", A);                       // LRU -> 1
        look("R3", C);                       // miss victim 1
        look("R3", C);                       // unchanged by miss
        fill("R6", A);                       // already present: LRU only
        cmd("R7", 2'd0, A);                  // lock A
        cmd("R7", 2'd0, C);                  // lock miss
        look("R4", B);                       // LRU -> 0 (A, locked)
        look("R4", C);                       // victim must be 1
        fill("R4", C);                       // replaces B
        look("R4", B);                       // now misses
        cmd("R5", 2'd0, C);                  // both locked
        look("R5", D);                       // no_alloc
        fill("R5", D);                       // blocked
        look("R5", C);                       // C survives
        look("R5", D);                       // still absent
        cmd("R8", 2'd1, A);                  // unlock A
        look("R8", A);                       // still valid
        look("R8", D);                       // victim 0 allowed again
        cmd("R9", 2'd2, C);                  // invalidate locked C
        look("R9", C);                       // miss, victim 1 (invalid)
        cmd("R9", 2'd2, C);                  // miss now
        fill("R9", C);                       // refill way 1
        look("R9", A);                       // LRU -> 1
        look("R9", D);                       // victim 1: lock cleared
        cmd("R9", 2'd3, C);                  // probe hit
        cmd("R9", 2'd3, D);                  // probe miss
        // R10: concurrent operations
        run_op("R10", 1, mk(7, 9, 0), 1, mk(7, 9, 0), 0, 2'd0, '0);
        look("R10", mk(7, 9, 0));
        run_op("R10", 0, '0, 1, mk(8, 9, 0), 1, 2'd0, mk(7, 9, 0));
        look("R10", mk(9, 9, 0));            // shows way 0 not locked by busy cmd
        run_op("R10", 1, mk(7, 9, 0), 0, '0, 1, 2'd2, mk(7, 9, 0));
        look("R10", mk(7, 9, 0));

        // R2..R10 random mix over a few sets and tags
        for (int i = 0; i < 400; i++) begin
            bit le, fe, ce;
            le = 1'($urandom_range(0, 1));
            fe = 1'($urandom_range(0, 1));
            ce = 1'($urandom_range(0, 1));
            run_op("R2", le, mk($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 15)),
                   fe, mk($urandom_range(0, 3), $urandom_range(0, 2), 0),
                   ce, 2'($urandom_range(0, 3)),
                   mk($urandom_range(0, 3), $urandom_range(0, 2), 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule